// File: doc/BRIEF.md
# Predicate Define Unit

This block holds a small file of one-bit predicate registers and updates it from predicate-define operations. A define compares two signed operands under one of six relations. It then combines the outcome with a guarding predicate and writes up to two destination predicates. Each destination has its own write rule. An unconditional rule always writes. An OR rule can only raise the bit. An AND rule can only drop the bit. Any rule may use the compare outcome inverted.

Software builds a disjunction by clearing a predicate and then issuing several OR-rule defines into it. It builds a conjunction by setting a predicate and then issuing several AND-rule defines into it. Explicit clear and set operations are provided for this. Any number of combinational read ports give the guard values to the rest of the datapath.

Predicate 0 always reads as true, so it can serve as the "always" guard. Every operation takes effect at the clock edge where it is presented. Its result shows on the read ports straight after that edge.

Top module: `pred_define_unit`

## Requirements
- R1: During and after reset, every predicate reads 0 except predicate 0, which reads 1.
- R2: The compare code selects a signed two's-complement relation of operand A to operand B. The codes are 0 equal, 1 not-equal, 2 less, 3 greater, 4 less-or-equal and 5 greater-or-equal.
- R3: A destination with kind 0 (unconditional) is written with guard AND e. Here e is the compare result, inverted when that destination's complement bit is 1. So a false guard writes 0.
- R4: A destination with kind 1 (OR) becomes 1 when guard AND e is true. Otherwise it keeps its value.
- R5: A destination with kind 2 (AND) becomes 0 when the guard is true and e is false. Otherwise it keeps its value.
- R6: The operation code is 0 no-op, 1 define, 2 clear and 3 set. Clear writes 0 and set writes 1 to the predicate named by destination 0, with no guard. A no-op changes nothing.
- R7: Predicate 0 reads 1 at all times. Defines, clears and sets aimed at it have no effect.
- R8: When both destinations write the same predicate in one define, the destination 1 value is stored.
- R9: Destination kind 3 writes nothing. Compare codes 6 and 7 produce a false result.
- R10: Every read port shows the named predicate combinationally. A write made at a clock edge is visible on all ports straight after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 2 | Operation code (R6) |
| cond_i | input | 3 | Compare code (R2) |
| src_a_i | input | 32 | Operand A, signed |
| src_b_i | input | 32 | Operand B, signed |
| guard_i | input | 4 | Index of the guarding predicate |
| dst0_i | input | 4 | Destination 0 index, also the clear/set target |
| dst0_kind_i | input | 2 | Destination 0 write kind |
| dst0_cmp_i | input | 1 | Destination 0 complement bit |
| dst1_i | input | 4 | Destination 1 index |
| dst1_kind_i | input | 2 | Destination 1 write kind |
| dst1_cmp_i | input | 1 | Destination 1 complement bit |
| rd_idx_i | input | 8 | Read indices, port k in bits [4k+3:4k] |
| rd_val_o | output | 2 | Read values, one bit per port |

## Verification
Every operation writes state that a read port shows one edge later. A wrong compare polarity or a wrong write rule therefore appears at the ports right after the faulty define. An accumulation bug is different. Where an OR rule drops a bit or an AND rule raises one, the error shows only when a later define in the same chain should have held the value. The stimulus therefore runs clear/OR and set/AND chains across several steps. It also covers guard-false cases and defines in which both destinations name the same predicate.

// File: rtl/pdu_pkg.sv
package pdu_pkg;
    typedef enum logic [1:0] {
        OP_NOP    = 2'd0,
        OP_DEFINE = 2'd1,
        OP_CLEAR  = 2'd2,
        OP_SET    = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        C_EQ = 3'd0,
        C_NE = 3'd1,
        C_LT = 3'd2,
        C_GT = 3'd3,
        C_LE = 3'd4,
        C_GE = 3'd5
    } cond_e;

    typedef enum logic [1:0] {
        K_UNC  = 2'd0,
        K_OR   = 2'd1,
        K_AND  = 2'd2,
        K_NONE = 2'd3
    } kind_e;
endpackage

// File: rtl/pdu_compare.sv
module pdu_compare #(
    parameter int DATA_W = 32
) (
    input  logic [2:0]        cond_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic              res_o
);
    import pdu_pkg::*;

    logic signed [DATA_W-1:0] sa, sb;
    assign sa = a_i;
    assign sb = b_i;

    always_comb begin
        unique case (cond_e'(cond_i))
            C_EQ:    res_o = (sa == sb);
            C_NE:    res_o = (sa != sb);
            C_LT:    res_o = (sa <  sb);
            C_GT:    res_o = (sa >  sb);
            C_LE:    res_o = (sa <= sb);
            C_GE:    res_o = (sa >= sb);
            default: res_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/pdu_dest_rule.sv
module pdu_dest_rule (
    input  logic       en_i,
    input  logic       guard_i,
    input  logic       res_i,
    input  logic [1:0] kind_i,
    input  logic       cmp_i,
    output logic       we_o,
    output logic       val_o
);
    import pdu_pkg::*;

    logic eff;
    assign eff = res_i ^ cmp_i;

    always_comb begin
        we_o  = 1'b0;
        val_o = 1'b0;
        unique case (kind_e'(kind_i))
            K_UNC: begin
                we_o  = en_i;
                val_o = guard_i & eff;
            end
            K_OR: begin
                we_o  = en_i & guard_i & eff;
                val_o = 1'b1;
            end
            K_AND: begin
                we_o  = en_i & guard_i & ~eff;
                val_o = 1'b0;
            end
            K_NONE: begin
                we_o  = 1'b0;
                val_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/pdu_regfile.sv
module pdu_regfile #(
    parameter int NPRED    = 16,
    parameter int RD_PORTS = 2,
    localparam int IW      = $clog2(NPRED)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we0_i,
    input  logic [IW-1:0]          idx0_i,
    input  logic                   val0_i,
    input  logic                   we1_i,
    input  logic [IW-1:0]          idx1_i,
    input  logic                   val1_i,
    input  logic [RD_PORTS*IW-1:0] rd_idx_i,
    output logic [RD_PORTS-1:0]    rd_val_o,
    output logic [NPRED-1:0]       pred_o
);
    logic [NPRED-1:0] pred_q;

    // Entry 0 is a constant true; no storage behind it.
    assign pred_q[0] = 1'b1;

    for (genvar g = 1; g < NPRED; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)
                pred_q[g] <= 1'b0;
            else if (we1_i && idx1_i == IW'(g))
                pred_q[g] <= val1_i;   // second destination has priority
            else if (we0_i && idx0_i == IW'(g))
                pred_q[g] <= val0_i;
        end
    end

    for (genvar r = 0; r < RD_PORTS; r++) begin : g_rd
        assign rd_val_o[r] = pred_q[rd_idx_i[r*IW +: IW]];
    end

    assign pred_o = pred_q;

    assert_collision_second_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (we0_i && we1_i && idx0_i == idx1_i && idx1_i != '0)
        |=> pred_q[$past(idx1_i)] == $past(val1_i));

    assert_single_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (we0_i && !(we1_i && idx1_i == idx0_i) && idx0_i != '0)
        |=> pred_q[$past(idx0_i)] == $past(val0_i));
endmodule

// File: rtl/pred_define_unit.sv
module pred_define_unit #(
    parameter int NPRED    = 16,
    parameter int DATA_W   = 32,
    parameter int RD_PORTS = 2,
    localparam int IW      = $clog2(NPRED)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             op_i,
    input  logic [2:0]             cond_i,
    input  logic [DATA_W-1:0]      src_a_i,
    input  logic [DATA_W-1:0]      src_b_i,
    input  logic [IW-1:0]          guard_i,
    input  logic [IW-1:0]          dst0_i,
    input  logic [1:0]             dst0_kind_i,
    input  logic                   dst0_cmp_i,
    input  logic [IW-1:0]          dst1_i,
    input  logic [1:0]             dst1_kind_i,
    input  logic                   dst1_cmp_i,
    input  logic [RD_PORTS*IW-1:0] rd_idx_i,
    output logic [RD_PORTS-1:0]    rd_val_o
);
    import pdu_pkg::*;

    logic [NPRED-1:0] pred_q;
    logic             is_def, guard_v, res;
    logic             r0_we, r0_val, r1_we, r1_val;
    logic             we0, val0;

    assign is_def  = (op_e'(op_i) == OP_DEFINE);
    assign guard_v = pred_q[guard_i];

    pdu_compare #(.DATA_W(DATA_W)) u_cmp (
        .cond_i (cond_i),
        .a_i    (src_a_i),
        .b_i    (src_b_i),
        .res_o  (res)
    );

    pdu_dest_rule u_rule0 (
        .en_i    (is_def),
        .guard_i (guard_v),
        .res_i   (res),
        .kind_i  (dst0_kind_i),
        .cmp_i   (dst0_cmp_i),
        .we_o    (r0_we),
        .val_o   (r0_val)
    );

    pdu_dest_rule u_rule1 (
        .en_i    (is_def),
        .guard_i (guard_v),
        .res_i   (res),
        .kind_i  (dst1_kind_i),
        .cmp_i   (dst1_cmp_i),
        .we_o    (r1_we),
        .val_o   (r1_val)
    );

    // Port 0 also carries the unguarded clear and set.
    always_comb begin
        unique case (op_e'(op_i))
            OP_CLEAR:  begin we0 = 1'b1;  val0 = 1'b0;   end
            OP_SET:    begin we0 = 1'b1;  val0 = 1'b1;   end
            OP_DEFINE: begin we0 = r0_we; val0 = r0_val; end
            default:   begin we0 = 1'b0;  val0 = 1'b0;   end
        endcase
    end

    pdu_regfile #(.NPRED(NPRED), .RD_PORTS(RD_PORTS)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .we0_i    (we0),
        .idx0_i   (dst0_i),
        .val0_i   (val0),
        .we1_i    (r1_we),
        .idx1_i   (dst1_i),
        .val1_i   (r1_val),
        .rd_idx_i (rd_idx_i),
        .rd_val_o (rd_val_o),
        .pred_o   (pred_q)
    );

    assert_p0_true_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pred_q[0] == 1'b1);

    assert_nop_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e'(op_i) == OP_NOP) |=> $stable(pred_q));

    assert_or_never_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_def && kind_e'(dst0_kind_i) == K_OR && dst1_i != dst0_i)
        |=> (pred_q[$past(dst0_i)] || !$past(pred_q[dst0_i])));

    assert_and_never_raises_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_def && kind_e'(dst0_kind_i) == K_AND && dst1_i != dst0_i)
        |=> (!pred_q[$past(dst0_i)] || $past(pred_q[dst0_i])));

    assert_false_guard_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_def && kind_e'(dst0_kind_i) == K_UNC && !pred_q[guard_i]
         && dst0_i != '0 && dst1_i != dst0_i)
        |=> !pred_q[$past(dst0_i)]);
endmodule

// File: tb/pred_define_unit_bench.sv
`timescale 1ns/1ps
module pred_define_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  op = 2'd0;
    logic [2:0]  cond = 3'd0;
    logic [31:0] a = 32'd0, b = 32'd0;
    logic [3:0]  g = 4'd0, d0 = 4'd0, d1 = 4'd0;
    logic [1:0]  k0 = 2'd3, k1 = 2'd3;
    logic        c0 = 1'b0, c1 = 1'b0;
    logic [7:0]  rd_idx = 8'd0;
    logic [1:0]  rd_val;
    int          tests = 0;
    int          fails = 0;

    always #2 clk = ~clk;

    pred_define_unit u_pred_define_unit (
        .clk(clk), .rst_n(rst_n), .op_i(op), .cond_i(cond),
        .src_a_i(a), .src_b_i(b), .guard_i(g),
        .dst0_i(d0), .dst0_kind_i(k0), .dst0_cmp_i(c0),
        .dst1_i(d1), .dst1_kind_i(k1), .dst1_cmp_i(c1),
        .rd_idx_i(rd_idx), .rd_val_o(rd_val)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic [2:0]  cond;
        logic [31:0] a;
        logic [31:0] b;
        logic [3:0]  g;
        logic [3:0]  d0;
        logic [1:0]  k0;
        logic        c0;
        logic [3:0]  d1;
        logic [1:0]  k1;
        logic        c1;
        logic [3:0]  chk;
        logic        exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VECS [NV] = '{
        '{2'd1,3'd0,32'd5,32'd5,4'd0,4'd1,2'd0,1'b0,4'd0,2'd3,1'b0,4'd1,1'b1,4'd3},   // R3
        '{2'd1,3'd0,32'd5,32'd6,4'd0,4'd2,2'd0,1'b1,4'd0,2'd3,1'b0,4'd2,1'b1,4'd3},   // R3 complement
        '{2'd1,3'd2,32'hFFFFFFFF,32'd1,4'd0,4'd3,2'd0,1'b0,4'd0,2'd3,1'b0,4'd3,1'b1,4'd2}, // R2 signed less
        '{2'd1,3'd3,32'hFFFFFFFF,32'd1,4'd0,4'd3,2'd0,1'b0,4'd0,2'd3,1'b0,4'd3,1'b0,4'd2}, // R2 greater
        '{2'd1,3'd1,32'd7,32'd7,4'd0,4'd4,2'd0,1'b1,4'd0,2'd3,1'b0,4'd4,1'b1,4'd2},   // R2 not-equal
        '{2'd1,3'd4,32'd3,32'd3,4'd0,4'd5,2'd0,1'b0,4'd0,2'd3,1'b0,4'd5,1'b1,4'd2},   // R2 le
        '{2'd1,3'd5,32'd2,32'd3,4'd0,4'd5,2'd0,1'b0,4'd0,2'd3,1'b0,4'd5,1'b0,4'd2},   // R2 ge
        '{2'd1,3'd3,32'h7FFFFFFF,32'h80000000,4'd0,4'd6,2'd0,1'b0,4'd0,2'd3,1'b0,4'd6,1'b1,4'd2}, // R2
        '{2'd1,3'd0,32'd1,32'd1,4'd7,4'd1,2'd0,1'b0,4'd0,2'd3,1'b0,4'd1,1'b0,4'd3},   // R3 false guard
        '{2'd2,3'd0,32'd0,32'd0,4'd0,4'd8,2'd0,1'b0,4'd0,2'd3,1'b0,4'd8,1'b0,4'd6},   // R6 clear
        '{2'd1,3'd0,32'd1,32'd2,4'd0,4'd8,2'd1,1'b0,4'd0,2'd3,1'b0,4'd8,1'b0,4'd4},   // R4 hold 0
        '{2'd1,3'd0,32'd1,32'd1,4'd0,4'd8,2'd1,1'b0,4'd0,2'd3,1'b0,4'd8,1'b1,4'd4},   // R4 raise
        '{2'd1,3'd0,32'd1,32'd2,4'd0,4'd8,2'd1,1'b0,4'd0,2'd3,1'b0,4'd8,1'b1,4'd4},   // R4 hold 1
        '{2'd3,3'd0,32'd0,32'd0,4'd0,4'd9,2'd0,1'b0,4'd0,2'd3,1'b0,4'd9,1'b1,4'd6},   // R6 set
        '{2'd1,3'd0,32'd1,32'd1,4'd0,4'd9,2'd2,1'b0,4'd0,2'd3,1'b0,4'd9,1'b1,4'd5},   // R5 hold 1
        '{2'd1,3'd0,32'd1,32'd2,4'd0,4'd9,2'd2,1'b0,4'd0,2'd3,1'b0,4'd9,1'b0,4'd5},   // R5 drop
        '{2'd1,3'd0,32'd1,32'd1,4'd0,4'd9,2'd2,1'b0,4'd0,2'd3,1'b0,4'd9,1'b0,4'd5},   // R5 hold 0
        '{2'd3,3'd0,32'd0,32'd0,4'd0,4'd9,2'd0,1'b0,4'd0,2'd3,1'b0,4'd9,1'b1,4'd6},   // R6 set
        '{2'd1,3'd0,32'd1,32'd2,4'd7,4'd9,2'd2,1'b0,4'd0,2'd3,1'b0,4'd9,1'b1,4'd5},   // R5 false guard
        '{2'd2,3'd0,32'd0,32'd0,4'd0,4'd10,2'd0,1'b0,4'd0,2'd3,1'b0,4'd10,1'b0,4'd6}, // R6 clear
        '{2'd1,3'd0,32'd1,32'd2,4'd0,4'd10,2'd1,1'b1,4'd0,2'd3,1'b0,4'd10,1'b1,4'd4}, // R4 complement
        '{2'd1,3'd0,32'd1,32'd1,4'd0,4'd13,2'd0,1'b0,4'd13,2'd0,1'b1,4'd13,1'b0,4'd8}, // R8
        '{2'd1,3'd0,32'd1,32'd1,4'd0,4'd13,2'd0,1'b1,4'd13,2'd0,1'b0,4'd13,1'b1,4'd8}, // R8
        '{2'd1,3'd0,32'd1,32'd2,4'd0,4'd0,2'd0,1'b0,4'd0,2'd3,1'b0,4'd0,1'b1,4'd7},   // R7 define
        '{2'd2,3'd0,32'd0,32'd0,4'd0,4'd0,2'd0,1'b0,4'd0,2'd3,1'b0,4'd0,1'b1,4'd7},   // R7 clear
        '{2'd1,3'd0,32'd1,32'd1,4'd0,4'd1,2'd3,1'b0,4'd0,2'd3,1'b0,4'd1,1'b0,4'd9},   // R9 kind 3
        '{2'd1,3'd6,32'd1,32'd1,4'd0,4'd1,2'd0,1'b1,4'd0,2'd3,1'b0,4'd1,1'b1,4'd9},   // R9 code 6
        '{2'd0,3'd0,32'd1,32'd2,4'd0,4'd1,2'd0,1'b0,4'd0,2'd3,1'b0,4'd1,1'b1,4'd6},   // R6 no-op
        '{2'd1,3'd0,32'd4,32'd4,4'd8,4'd14,2'd0,1'b0,4'd0,2'd3,1'b0,4'd14,1'b1,4'd3}, // R3 guard p8
        '{2'd1,3'd5,32'hFFFFFFFB,32'hFFFFFFFB,4'd0,4'd15,2'd0,1'b0,4'd0,2'd3,1'b0,4'd15,1'b1,4'd2} // R2
    };

    task automatic check(input logic act, input logic exp, input string tag);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        op = 2'd0; k0 = 2'd3; k1 = 2'd3;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: state while reset is held
        rd_idx = {4'd5, 4'd0};
        #0.1;
        check(rd_val[0], 1'b1, "R1 p0 in reset");
        check(rd_val[1], 1'b0, "R1 p5 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 16; i++) begin
            rd_idx = {4'd0, 4'(i)};
            #0.1;
            check(rd_val[0], (i == 0), $sformatf("R1 p%0d after reset", i));
        end

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            op = VECS[v].op; cond = VECS[v].cond; a = VECS[v].a; b = VECS[v].b;
            g = VECS[v].g; d0 = VECS[v].d0; k0 = VECS[v].k0; c0 = VECS[v].c0;
            d1 = VECS[v].d1; k1 = VECS[v].k1; c1 = VECS[v].c1;
            rd_idx = {4'd0, VECS[v].chk};
            @(posedge clk);
            @(negedge clk);
            idle_inputs();
            check(rd_val[0], VECS[v].exp,
                  $sformatf("R%0d vector %0d p%0d", VECS[v].req, v, VECS[v].chk));
        end

        // R10: two destinations, both read ports, visible right after the edge
        @(negedge clk);
        op = 2'd1; cond = 3'd2; a = 32'd1; b = 32'd2; g = 4'd0;
        d0 = 4'd11; k0 = 2'd0; c0 = 1'b0;
        d1 = 4'd12; k1 = 2'd1; c1 = 1'b0;
        rd_idx = {4'd12, 4'd11};
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
        check(rd_val[0], 1'b1, "R10 port0 p11");
        check(rd_val[1], 1'b1, "R10 port1 p12");

        // R1: reset in mid-run clears written predicates
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        rd_idx = {4'd8, 4'd0};
        #0.1;
        check(rd_val[0], 1'b1, "R1 p0 after second reset");
        check(rd_val[1], 1'b0, "R1 p8 after second reset");

        finish_run();
    end
endmodule